// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an up-only 8-bit counter that takes one asynchronous input pin and counts either its transitions or the time it spends at one level. In edge mode every selected transition of the resynchronized pin adds one. In gated-time mode the counter adds one on every cycle where an externally supplied tick enable is high and the resynchronized pin is at its active level. The tick enable comes from a prescaler outside the block.

Software reaches three registers through a small synchronous write port and a combinational read port. It can load the counter at any time. Loading `256 - N` means that the N-th counted event wraps the counter from FF to 00. The wrap sets a sticky overflow flag, and that flag drives the interrupt line when interrupts are enabled. Typical uses are "interrupt after N pulses" and measuring how long a pulse is in prescaled ticks.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register (address 0), the count (address 1) and the status register (address 2) read 00, and `irq` is low. Address 3 always reads 00. Control bits: bit0 run, bit1 mode (0 edge, 1 gated), bit2 invert, bit3 interrupt enable. Status bit0 is the overflow flag.
- R2: With run=1, mode=0 and invert=0, each rising transition of `pin_in` adds one to the count. The new value is readable after the third rising clock edge that follows the pin change, and `tick_en` plays no part in this mode.
- R3: With run=1, mode=0 and invert=1, only falling transitions of `pin_in` add one. Rising transitions leave the count unchanged.
- R4: With run=1 and mode=1, the count adds one on each clock cycle in which `tick_en` is high and the synchronized pin is at its active level. The active level is high when invert=0 and low when invert=1. No count is added while the pin is at the other level.
- R5: With run=0, neither pin transitions nor ticks change the count.
- R6: A counted event when the count is FF makes the count 00 and sets the overflow flag. A preloaded value therefore fixes how many events pass before the flag is set.
- R7: `irq` is high exactly when the overflow flag and the interrupt enable bit are both 1.
- R8: The overflow flag stays set until software writes 1 to status bit0. Writing 0 to that bit has no effect.
- R9: A software write to the count takes priority over an increment in the same cycle. The written value is the one held afterwards, and counting resumes from it.
- R10: If a wrap and a write-1 to status bit0 happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous external pulse input |
| tick_en | input | 1 | Prescaled time tick used in gated mode |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions: a count write landing on a cycle that would also increment, and a wrap landing on the cycle of a flag clear. In edge mode the timing depends on the synchronizer delay, so it is hard to control. The bench therefore uses gated mode with the pin held active and `tick_en` held high, which makes the counter advance on every clock. A count write is placed on a known clock edge, and the write-1 clear is issued on the next edge, when the preloaded FF wraps.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

    typedef enum logic {
        MODE_EDGE  = 1'b0,
        MODE_GATED = 1'b1
    } acc_mode_e;

    // Packed from MSB to LSB: bit3 irq_en, bit2 invert, bit1 mode, bit0 run
    typedef struct packed {
        logic      irq_en;
        logic      invert;
        acc_mode_e mode;
        logic      run;
    } acc_ctrl_t;

    localparam int CTRL_W = $bits(acc_ctrl_t);

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_d, chain_q;
    logic              last_d, last_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_async};
        last_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~last_q;
    assign fall  = ~level & last_q;

    // R2: a detected rising transition lasts a single cycle
    a_r2_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R3: a detected falling transition lasts a single cycle
    a_r3_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/pacc_qualifier.sv
module pacc_qualifier
    import pacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  acc_ctrl_t ctrl,
    input  logic      level,
    input  logic      rise,
    input  logic      fall,
    input  logic      tick_en,
    output logic      inc
);

    logic hit;

    always_comb begin
        unique case (ctrl.mode)
            MODE_EDGE:  hit = ctrl.invert ? fall : rise;
            MODE_GATED: hit = tick_en & (level ^ ctrl.invert);
            default:    hit = 1'b0;
        endcase
        inc = ctrl.run & hit;
    end

    // R4: in gated mode an increment needs a tick and the active level
    a_r4_gated_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && ctrl.mode == MODE_GATED) |-> (tick_en && (level != ctrl.invert)));

    // R5: nothing is counted while run is clear
    a_r5_idle_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !inc);

endmodule

// File: rtl/pacc_regs.sv
module pacc_regs
    import pacc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output acc_ctrl_t         ctrl,
    output logic              ovf,
    output logic [CNT_W-1:0]  rdata
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        acc_ctrl_t        ctrl;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_ctrl, wr_cnt, wr_stat, clr_req, wrap;

    always_comb begin
        regs_d  = regs_q;
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_cnt  = reg_wr && (reg_addr == ADDR_COUNT);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        clr_req = wr_stat && reg_wdata[0];
        wrap    = inc && !wr_cnt && (regs_q.cnt == CNT_TOP);

        if (wr_ctrl)
            regs_d.ctrl = acc_ctrl_t'(reg_wdata[CTRL_W-1:0]);

        if (wr_cnt)
            regs_d.cnt = reg_wdata;
        else if (inc)
            regs_d.cnt = regs_q.cnt + 1'b1;

        if (wrap)
            regs_d.ovf = 1'b1;
        else if (clr_req)
            regs_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL:  rdata[CTRL_W-1:0] = regs_q.ctrl;
            ADDR_COUNT: rdata = regs_q.cnt;
            ADDR_STAT:  rdata[0] = regs_q.ovf;
            default:    rdata = '0;
        endcase
    end

    assign ctrl = regs_q.ctrl;
    assign ovf  = regs_q.ovf;

    // R6: counting past the top value wraps to zero and raises the flag
    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_cnt && regs_q.cnt == CNT_TOP) |=> (regs_q.cnt == '0 && regs_q.ovf));

    // R8: the flag only falls through a write of 1
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ovf && !(wr_stat && reg_wdata[0])) |=> regs_q.ovf);

    // R9: a count write beats a simultaneous increment
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (regs_q.cnt == $past(reg_wdata)));

    // R10: a wrap beats a clear in the same cycle
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_cnt && regs_q.cnt == CNT_TOP && wr_stat && reg_wdata[0]) |=> regs_q.ovf);

    // R5: without an increment or a write the count holds
    a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_cnt) |=> $stable(regs_q.cnt));

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);

    logic      pin_level, pin_rise, pin_fall, do_inc, ovf_flag;
    acc_ctrl_t ctrl;

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .level     (pin_level),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    pacc_qualifier u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .level   (pin_level),
        .rise    (pin_rise),
        .fall    (pin_fall),
        .tick_en (tick_en),
        .inc     (do_inc)
    );

    pacc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (do_inc),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ctrl      (ctrl),
        .ovf       (ovf_flag),
        .rdata     (reg_rdata)
    );

    assign irq = ovf_flag & ctrl.irq_en;

    // R7: an interrupt is only ever raised with the flag set
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);

endmodule

// File: tb/pulse_accum_test.sv
module pulse_accum_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_STAT = 2'd2;

    always #10 clk = ~clk;

    pulse_accum uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .tick_en   (tick_en),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            pin_in = ~pin_in;
            step(4);
            pin_in = ~pin_in;
            step(4);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
        rd(A_CNT, v);  check("R1 count", v, 8'h00);
        rd(A_STAT, v); check("R1 status", v, 8'h00);
        rd(2'd3, v);   check("R1 unmapped", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_rising();
        logic [7:0] v;
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); check("R1 ctrl readback", v, 8'h01);
        pin_in = 1'b1;
        step(2);
        rd(A_CNT, v); check("R2 not yet counted", v, 8'h00);
        step(1);
        rd(A_CNT, v); check("R2 third edge", v, 8'h01);
        step(3);
        pin_in = 1'b0;
        step(4);
        pulses(4);
        rd(A_CNT, v); check("R2 rising count", v, 8'h05);
    endtask

    task automatic t_falling();
        logic [7:0] v;
        wr(A_CTRL, 8'h05);
        wr(A_CNT, 8'h00);
        pin_in = 1'b1;
        step(4);
        rd(A_CNT, v); check("R3 rising ignored", v, 8'h00);
        pin_in = 1'b0;
        step(4);
        rd(A_CNT, v); check("R3 falling counted", v, 8'h01);
        pin_in = 1'b1; step(4); pin_in = 1'b0; step(4);
        pin_in = 1'b1; step(4); pin_in = 1'b0; step(4);
        rd(A_CNT, v); check("R3 falling count", v, 8'h03);
    endtask

    task automatic t_gated_high();
        logic [7:0] v;
        wr(A_CTRL, 8'h03);
        wr(A_CNT, 8'h00);
        pin_in = 1'b1;
        step(4);
        rd(A_CNT, v); check("R4 no tick no count", v, 8'h00);
        tick_en = 1'b1; step(6); tick_en = 1'b0;
        rd(A_CNT, v); check("R4 high ticks", v, 8'h06);
        pin_in = 1'b0;
        step(4);
        tick_en = 1'b1; step(5); tick_en = 1'b0;
        rd(A_CNT, v); check("R4 inactive low", v, 8'h06);
    endtask

    task automatic t_gated_low();
        logic [7:0] v;
        wr(A_CTRL, 8'h07);
        wr(A_CNT, 8'h00);
        tick_en = 1'b1; step(4); tick_en = 1'b0;
        rd(A_CNT, v); check("R4 low ticks", v, 8'h04);
        pin_in = 1'b1;
        step(4);
        tick_en = 1'b1; step(5); tick_en = 1'b0;
        rd(A_CNT, v); check("R4 inactive high", v, 8'h04);
        pin_in = 1'b0;
        step(4);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h20);
        pulses(3);
        rd(A_CNT, v); check("R5 edges ignored", v, 8'h20);
        wr(A_CTRL, 8'h02);
        pin_in = 1'b1; step(4);
        tick_en = 1'b1; step(5); tick_en = 1'b0;
        pin_in = 1'b0; step(4);
        rd(A_CNT, v); check("R5 ticks ignored", v, 8'h20);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(A_CTRL, 8'h09);
        wr(A_CNT, 8'hFD);
        pulses(2);
        rd(A_CNT, v);  check("R6 before wrap", v, 8'hFF);
        rd(A_STAT, v); check("R6 flag clear", v, 8'h00);
        check("R7 irq low", {7'd0, irq}, 8'h00);
        pulses(1);
        rd(A_CNT, v);  check("R6 wrapped", v, 8'h00);
        rd(A_STAT, v); check("R6 flag set", v, 8'h01);
        check("R7 irq high", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_irq_mask();
        logic [7:0] v;
        wr(A_CTRL, 8'h01);
        check("R7 irq masked", {7'd0, irq}, 8'h00);
        rd(A_STAT, v); check("R7 flag kept", v, 8'h01);
        wr(A_CTRL, 8'h09);
        check("R7 irq unmasked", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); check("R8 write 0 ignored", v, 8'h01);
        wr(A_STAT, 8'h01);
        rd(A_STAT, v); check("R8 write 1 clears", v, 8'h00);
        check("R8 irq dropped", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        wr(A_CTRL, 8'h03);
        pin_in = 1'b1;
        step(4);
        wr(A_CNT, 8'h00);
        tick_en = 1'b1;
        step(3);
        rd(A_CNT, v); check("R9 running", v, 8'h03);
        wr(A_CNT, 8'h40);
        rd(A_CNT, v); check("R9 write wins", v, 8'h40);
        step(1);
        tick_en = 1'b0;
        rd(A_CNT, v); check("R9 resumes", v, 8'h41);
    endtask

    task automatic t_set_vs_clear();
        logic [7:0] v;
        tick_en = 1'b1;
        wr(A_CNT, 8'hFF);
        wr(A_STAT, 8'h01);
        tick_en = 1'b0;
        rd(A_CNT, v);  check("R10 wrapped", v, 8'h00);
        rd(A_STAT, v); check("R10 set beats clear", v, 8'h01);
        wr(A_STAT, 8'h01);
        rd(A_STAT, v); check("R10 later clear", v, 8'h00);
        pin_in = 1'b0;
        step(4);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_rising();
        t_falling();
        t_gated_high();
        t_gated_low();
        t_disabled();
        t_wrap();
        t_irq_mask();
        t_w1c();
        t_priority();
        t_set_vs_clear();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule